// File: doc/BRIEF.md
# XOR-Encoded Multi-Port RAM

This block presents one word-addressed memory through four ports: three that can each read or write, and one that can only read. It is built from three ordinary storage banks, each with a single write port. Read/write port A writes only bank A, port B only bank B and port C only bank C. Because no bank is shared between writers, no arbitration is needed.

The logical word at an address is the XOR of the three banks at that address. When a port writes, its own bank stores the new data XORed with the other two banks at the same address. The XOR across all three banks then gives back exactly the new data. Every read port XORs the three banks at its own address, without a register on the path. Each read/write port uses one address for both its read and its write.

Bank writes take effect on the rising clock edge. A read of a word that is being written in the same cycle returns the old word, and the new word is visible after the edge. If two or more ports write the same address in one cycle, the result is undefined, and callers must not do this. Memory contents are not cleared. The block has no control sequencing, so it has no state machine.

Top module: `xor_multiport_ram`

## Requirements
- R1: After a rising edge at which port A wrote data D to address X (with no other port writing X), every port whose address is X returns D.
- R2: After a rising edge at which port B wrote data D to address X (with no other port writing X), every port whose address is X returns D.
- R3: After a rising edge at which port C wrote data D to address X (with no other port writing X), every port whose address is X returns D.
- R4: The read-only port returns the logical word at its own address, and any two ports set to the same address return the same data.
- R5: In the cycle in which a port writes address X, reads of X on any port still return the word held before that edge.
- R6: All three read/write ports can write different addresses in the same cycle, and every one of those writes lands.
- R7: In a cycle with no write enable asserted, no stored word changes.
- R8: Read data follows a change of read address in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bank writes on the rising edge |
| a_addr | input | AW | Port A address, used for both read and write |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data |
| b_addr | input | AW | Port B address, used for both read and write |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data |
| c_addr | input | AW | Port C address, used for both read and write |
| c_we | input | 1 | Port C write enable |
| c_wdata | input | DW | Port C write data |
| c_rdata | output | DW | Port C read data |
| d_addr | input | AW | Read-only port address |
| d_rdata | output | DW | Read-only port read data |

## Verification
The hardest case to reach from the ports is a word whose three bank slices all hold non-trivial values. In that case the encoding is correct only if each writer folded in the current slices of the other two banks. The stimulus reaches this case by having ports A, B and C overwrite the same address one after another, each over a word last written by a different port. It then reads that word back through all four ports at once. A separate phase fills every address with three concurrent writes and sweeps the read-only port over the whole memory, both before and after idle cycles.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
    localparam int XMP_NRW   = 3;
    localparam int XMP_NPORT = 4;

    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_C = 2'd2,
        PORT_D = 2'd3
    } xmp_port_e;
endpackage

// File: rtl/xmp_bank.sv
module xmp_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int NRD   = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r] = store[raddr[r]];
    end
endmodule

// File: rtl/xmp_encode.sv
module xmp_encode #(
    parameter int DW   = 16,
    parameter int NB   = 3,
    parameter int SELF = 0
) (
    input  logic [NB-1:0][DW-1:0] slices,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         enc
);
    always_comb begin
        enc = wdata;
        for (int j = 0; j < NB; j++) begin
            if (j != SELF) begin
                enc = enc ^ slices[j];
            end
        end
    end
endmodule

// File: rtl/xmp_decode.sv
module xmp_decode #(
    parameter int DW = 16,
    parameter int NB = 3
) (
    input  logic [NB-1:0][DW-1:0] slices,
    output logic [DW-1:0]         word
);
    always_comb begin
        word = '0;
        for (int j = 0; j < NB; j++) begin
            word = word ^ slices[j];
        end
    end
endmodule

// File: rtl/xor_multiport_ram.sv
module xor_multiport_ram
    import xmp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    input  logic [AW-1:0] c_addr,
    input  logic          c_we,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] c_rdata,
    input  logic [AW-1:0] d_addr,
    output logic [DW-1:0] d_rdata
);
    localparam int NB = XMP_NRW;
    localparam int NP = XMP_NPORT;

    logic [NP-1:0][AW-1:0]          port_addr;
    logic [NB-1:0]                  port_we;
    logic [NB-1:0][DW-1:0]          port_wdata;
    logic [NB-1:0][DW-1:0]          bank_wdata;
    logic [NB-1:0][NP-1:0][DW-1:0]  bank_rd;
    logic [NP-1:0][NB-1:0][DW-1:0]  port_slices;
    logic [NP-1:0][DW-1:0]          port_rdata;

    assign port_addr[PORT_A]  = a_addr;
    assign port_addr[PORT_B]  = b_addr;
    assign port_addr[PORT_C]  = c_addr;
    assign port_addr[PORT_D]  = d_addr;
    assign port_we[PORT_A]    = a_we;
    assign port_we[PORT_B]    = b_we;
    assign port_we[PORT_C]    = c_we;
    assign port_wdata[PORT_A] = a_wdata;
    assign port_wdata[PORT_B] = b_wdata;
    assign port_wdata[PORT_C] = c_wdata;

    for (genvar k = 0; k < NB; k++) begin : g_bank
        xmp_bank #(
            .DW(DW), .DEPTH(DEPTH), .AW(AW), .NRD(NP)
        ) bank_i (
            .clk   (clk),
            .we    (port_we[k]),
            .waddr (port_addr[k]),
            .wdata (bank_wdata[k]),
            .raddr (port_addr),
            .rdata (bank_rd[k])
        );

        xmp_encode #(
            .DW(DW), .NB(NB), .SELF(k)
        ) enc_i (
            .slices (port_slices[k]),
            .wdata  (port_wdata[k]),
            .enc    (bank_wdata[k])
        );
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        for (genvar k = 0; k < NB; k++) begin : g_slice
            assign port_slices[p][k] = bank_rd[k][p];
        end

        xmp_decode #(
            .DW(DW), .NB(NB)
        ) dec_i (
            .slices (port_slices[p]),
            .word   (port_rdata[p])
        );
    end

    assign a_rdata = port_rdata[PORT_A];
    assign b_rdata = port_rdata[PORT_B];
    assign c_rdata = port_rdata[PORT_C];
    assign d_rdata = port_rdata[PORT_D];
endmodule

// File: rtl/xmp_checker.sv
module xmp_checker #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input logic          clk,
    input logic [AW-1:0] a_addr,
    input logic          a_we,
    input logic [DW-1:0] a_wdata,
    input logic [DW-1:0] a_rdata,
    input logic [AW-1:0] b_addr,
    input logic          b_we,
    input logic [DW-1:0] b_wdata,
    input logic [DW-1:0] b_rdata,
    input logic [AW-1:0] c_addr,
    input logic          c_we,
    input logic [DW-1:0] c_wdata,
    input logic [DW-1:0] c_rdata,
    input logic [AW-1:0] d_addr,
    input logic [DW-1:0] d_rdata
);
    logic warm_q = 1'b0;

    always_ff @(posedge clk) begin
        warm_q <= 1'b1;
    end

    a_r1_a_write_lands: assert property (@(posedge clk) disable iff (!warm_q)
        (a_we && !(b_we && b_addr == a_addr) && !(c_we && c_addr == a_addr))
        |=> (a_addr != $past(a_addr)) || (a_rdata == $past(a_wdata)));

    a_r2_b_write_lands: assert property (@(posedge clk) disable iff (!warm_q)
        (b_we && !(a_we && a_addr == b_addr) && !(c_we && c_addr == b_addr))
        |=> (b_addr != $past(b_addr)) || (b_rdata == $past(b_wdata)));

    a_r3_c_write_lands: assert property (@(posedge clk) disable iff (!warm_q)
        (c_we && !(a_we && a_addr == c_addr) && !(b_we && b_addr == c_addr))
        |=> (c_addr != $past(c_addr)) || (c_rdata == $past(c_wdata)));

    a_r4_ports_agree: assert property (@(posedge clk) disable iff (!warm_q)
        (d_addr == a_addr) |-> (d_rdata == a_rdata));

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!warm_q)
        (!a_we && !b_we && !c_we)
        |=> (d_addr != $past(d_addr)) || $stable(d_rdata));
endmodule

bind xor_multiport_ram xmp_checker #(.DW(DW), .AW(AW)) chk_i (
    .clk(clk),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .d_addr(d_addr), .d_rdata(d_rdata)
);

// File: tb/xor_multiport_ram_tb.sv
module xor_multiport_ram_tb_top;
    localparam int DW    = 16;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    typedef struct packed {
        logic          wa; logic [AW-1:0] aa; logic [DW-1:0] da;
        logic          wb; logic [AW-1:0] ab; logic [DW-1:0] db;
        logic          wc; logic [AW-1:0] ac; logic [DW-1:0] dc;
        logic [AW-1:0] ad;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'd5,  16'h1111, 1'b1, 6'd9,  16'h2222, 1'b1, 6'd13, 16'h3333, 6'd5},
        '{1'b0, 6'd5,  16'h0000, 1'b0, 6'd9,  16'h0000, 1'b0, 6'd13, 16'h0000, 6'd9},
        '{1'b1, 6'd9,  16'hAAAA, 1'b1, 6'd13, 16'hBBBB, 1'b1, 6'd5,  16'hCCCC, 6'd9},
        '{1'b0, 6'd9,  16'h0000, 1'b0, 6'd13, 16'h0000, 1'b0, 6'd5,  16'h0000, 6'd13},
        '{1'b1, 6'd0,  16'hFFFF, 1'b1, 6'd63, 16'h0001, 1'b1, 6'd32, 16'h8000, 6'd0},
        '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd63, 16'h0000, 1'b0, 6'd32, 16'h0000, 6'd63},
        '{1'b1, 6'd20, 16'h1234, 1'b0, 6'd20, 16'h0000, 1'b0, 6'd20, 16'h0000, 6'd20},
        '{1'b0, 6'd20, 16'h0000, 1'b1, 6'd20, 16'h5678, 1'b0, 6'd20, 16'h0000, 6'd20},
        '{1'b0, 6'd20, 16'h0000, 1'b0, 6'd20, 16'h0000, 1'b1, 6'd20, 16'h9ABC, 6'd20},
        '{1'b0, 6'd20, 16'h0000, 1'b0, 6'd20, 16'h0000, 1'b0, 6'd20, 16'h0000, 6'd20},
        '{1'b1, 6'd40, 16'h0000, 1'b1, 6'd41, 16'hFFFF, 1'b1, 6'd42, 16'h5A5A, 6'd40},
        '{1'b0, 6'd41, 16'h0000, 1'b0, 6'd42, 16'h0000, 1'b0, 6'd40, 16'h0000, 6'd42}
    };

    logic          clk = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0, c_addr = '0, d_addr = '0;
    logic          a_we = 1'b0, b_we = 1'b0, c_we = 1'b0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0, c_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata, c_rdata, d_rdata;

    logic [DW-1:0] model [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    xor_multiport_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) dut_i (
        .clk(clk),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .d_addr(d_addr), .d_rdata(d_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check all four read ports against the model (pre-edge contents).
    task automatic check_ports();
        check(a_we ? "R5 port A" : "R1 port A", a_rdata, model[a_addr]);
        check(b_we ? "R5 port B" : "R2 port B", b_rdata, model[b_addr]);
        check(c_we ? "R5 port C" : "R3 port C", c_rdata, model[c_addr]);
        check("R4 port D", d_rdata, model[d_addr]);
    endtask

    // Wait for the edge, then commit the writes to the model.
    task automatic step();
        @(posedge clk);
        if (a_we) model[a_addr] = a_wdata;
        if (b_we) model[b_addr] = b_wdata;
        if (c_we) model[c_addr] = c_wdata;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R6: fill every word using three concurrent writes to distinct addresses.
        for (int base = 0; base < DEPTH; base += 3) begin
            a_we = 1'b1; a_addr = AW'(base);     a_wdata = DW'(base * 16'h0101 + 16'h0F);
            b_we = (base + 1 < DEPTH); b_addr = AW'(base + 1); b_wdata = DW'((base + 1) * 16'h0303 ^ 16'hC35A);
            c_we = (base + 2 < DEPTH); c_addr = AW'(base + 2); c_wdata = DW'((base + 2) * 16'h0707 ^ 16'h9E01);
            step();
        end
        a_we = 1'b0; b_we = 1'b0; c_we = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            d_addr = AW'(i);
            #1;
            check("R6 fill sweep", d_rdata, model[i]);
        end

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            a_we = VECS[v].wa; a_addr = VECS[v].aa; a_wdata = VECS[v].da;
            b_we = VECS[v].wb; b_addr = VECS[v].ab; b_wdata = VECS[v].db;
            c_we = VECS[v].wc; c_addr = VECS[v].ac; c_wdata = VECS[v].dc;
            d_addr = VECS[v].ad;
            #1;
            check_ports();
            step();
        end

        // R1/R2/R3 explicit: word 20 last written A, B then C -> 9ABC on all ports
        a_we = 1'b0; b_we = 1'b0; c_we = 1'b0;
        a_addr = 6'd20; b_addr = 6'd20; c_addr = 6'd20; d_addr = 6'd20;
        #1;
        check("R3 stacked overwrite", c_rdata, 16'h9ABC);
        check("R4 stacked overwrite", d_rdata, 16'h9ABC);
        a_addr = 6'd9; b_addr = 6'd13;
        #1;
        check("R1 port A overwrite of B word", a_rdata, 16'hAAAA);
        check("R2 port B overwrite of C word", b_rdata, 16'hBBBB);

        // R8: address change with no clock edge
        d_addr = 6'd40;
        #1;
        check("R8 comb read 40", d_rdata, 16'h0000);
        d_addr = 6'd41;
        #1;
        check("R8 comb read 41", d_rdata, 16'hFFFF);
        d_addr = 6'd42;
        #1;
        check("R8 comb read 42", d_rdata, 16'h5A5A);

        // R7: idle cycles with nonzero write data and moving addresses
        a_wdata = 16'hDEAD; b_wdata = 16'hBEEF; c_wdata = 16'h0BAD;
        for (int k = 0; k < 4; k++) begin
            a_addr = AW'(k); b_addr = AW'(k + 20); c_addr = AW'(k + 40);
            step();
        end
        for (int i = 0; i < DEPTH; i++) begin
            d_addr = AW'(i);
            #1;
            check("R7 idle sweep", d_rdata, model[i]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule